// File: doc/BRIEF.md
# UART Transmit Queue with Empty-Interrupt Holdoff

This block is the transmit half of a 16550-class serial port. Software writes bytes into a 16-deep queue. A framing engine pulls each byte into its shift register as soon as it is free and sends it on `txd`. The framing engine is paced by a 16x oversampling baud tick. No software action is needed beyond the write itself.

The block also raises the "transmit queue empty" interrupt. A naive version of this interrupt can pulse while a service routine is still refilling the queue, because the first byte may drain before the second byte arrives. To avoid this, a holdoff controller tracks the refill:

- State `HO_ARMED`: the queue is empty and the holdoff is armed.
- Transition `HO_ARMED` to `HO_FIRST`: a byte lands in the queue.
- Transition `HO_FIRST` to `HO_WAIT`: the queue empties while the holdoff is still armed. The controller then counts one full character time before it flags the interrupt, and returns to `HO_ARMED` when the count ends.
- Transition `HO_WAIT` to `HO_FIRST`: a write arrives during the wait. The wait is abandoned.
- Transition `HO_FIRST` to `HO_OPEN`: two bytes sit in the queue together, which disarms the holdoff.
- Transition `HO_OPEN` to `HO_ARMED`: the queue empties. The interrupt is flagged at once and the holdoff is armed again.

The framing engine has five states:

- `SER_IDLE`: the line is high. It moves to `SER_START` when it pops a byte.
- `SER_START`: it moves to `SER_DATA` after one bit time.
- `SER_DATA`: after the last data bit it moves to `SER_PARITY` if parity is on, otherwise to `SER_STOP`.
- `SER_PARITY`: it moves to `SER_STOP` after one bit time.
- `SER_STOP`: it moves back to `SER_IDLE` after the last stop bit.

Top module: `uart_txq_holdoff`

## Requirements
- R1: The queue holds at most 16 bytes. While it holds 16, a write is refused: `wr_ack` stays 0 and the byte is never sent. `wr_ack` is 1 during a cycle with `wr_en` high whenever the write is taken.
- R2: Once a byte moves from a full queue into the shift register, the next write is accepted again.
- R3: Accepted bytes leave on `txd` in write order, with no action other than the write. Each frame has:
  - a start bit of 0;
  - 8 data bits, least significant first;
  - when `par_en` is 1, a parity bit equal to the XOR of the data bits if `par_even` is 1, or its inverse if `par_even` is 0;
  - one stop bit of 1.

  Each bit lasts 16 `baud_tick` pulses. The idle line is 1.
- R4: `hold_empty` is 1 exactly when the queue is empty. `xmit_empty` is 1 only when both the queue and the shift register are empty.
- R5: `irq` equals the pending flag ANDed with `irq_en`. The pending flag is set out of reset, and it is kept while `irq_en` is 0.
- R6: An accepted write clears the pending flag.
- R7: A pulse on `irq_ack` clears the pending flag. This pulse is the identification read that reports the transmit source.
- R8: While the holdoff is armed and the queue empties, the pending flag is set only after one character time. That time is 16 times the frame bit count, counted in `baud_tick` pulses from the emptying.
- R9: A write during the holdoff wait cancels it. The wait restarts from the next emptying, and no interrupt is flagged for the cancelled one.
- R10: Once two bytes have been resident at the same time, the next emptying sets the pending flag in the following cycle. The holdoff is then armed again for the next byte.
- R11: A pulse on `fifo_clr` has these effects:
  - it drops the queued bytes;
  - it aborts the frame in progress, returning `txd` to 1;
  - it sets `hold_empty` and `xmit_empty`;
  - it sets the pending flag;
  - it re-arms the holdoff.
- R12: With `two_stop` set, a second stop bit of 1 follows. The frame bit count is 10, plus 1 when `par_en` is set, plus 1 when `two_stop` is set. This count sets the holdoff length in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous queue flush and transmitter abort |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | Byte to queue |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| irq_ack | input | 1 | Identification read that clears the pending transmit interrupt |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| two_stop | input | 1 | Send two stop bits |
| txd | output | 1 | Serial output |
| wr_ack | output | 1 | Current write is accepted |
| hold_empty | output | 1 | Queue is empty |
| xmit_empty | output | 1 | Queue and shift register both empty |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The embedded properties check the following on every cycle:

- the queue level never passes 16;
- a full queue with no pop stays full;
- the framing engine only pops from a non-empty queue;
- the line holds steady between baud ticks;
- the pending flag stays low throughout a holdoff wait;
- an accepted write or an acknowledge always leaves `irq` low in the next cycle;
- emptying in the disarmed state flags the interrupt one cycle later.

Only the scenarios can show the timing and content behaviours:

- the length of the holdoff window under different frame formats;
- the cancellation of a wait by a late write;
- the exact number of writes a full queue absorbs;
- the bit content and order of the serial frames;
- the re-arming after a flush.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_PARITY,
        SER_STOP
    } ser_state_e;

    typedef enum logic [1:0] {
        HO_ARMED,
        HO_FIRST,
        HO_WAIT,
        HO_OPEN
    } holdoff_state_e;

    // Bits in one character: start + data + optional parity + one or two stop.
    function automatic int unsigned frame_bits(input int unsigned data_bits,
                                               input logic par,
                                               input logic two);
        return 2 + data_bits + (par ? 1 : 0) + (two ? 1 : 0);
    endfunction

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    level,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wrap_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= wrap_inc(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_comb begin
        pop_data = store[rd_ptr];
        empty    = (level == '0);
        full     = (level == CW'(DEPTH));
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH))
        else $error("queue level above depth");

    p_full_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clr) |=> full)
        else $error("full queue changed level without a pop");

    p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("pop from empty queue");

endmodule

// File: rtl/txq_serializer.sv
module txq_serializer
    import uart_txq_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16,
    localparam int TW = $clog2(OVS),
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 baud_tick,
    input  logic                 par_en,
    input  logic                 par_even,
    input  logic                 two_stop,
    input  logic                 src_empty,
    input  logic [DATA_BITS-1:0] src_data,
    output logic                 src_pop,
    output logic                 txd,
    output logic                 busy
);

    ser_state_e           state;
    ser_state_e           state_nx;
    logic [DATA_BITS-1:0] shreg;
    logic [TW-1:0]        tick_cnt;
    logic [IW-1:0]        bit_idx;
    logic                 par_bit;
    logic                 use_par;
    logic                 extra_stop;
    logic                 bit_end;

    always_comb begin
        bit_end = baud_tick && (tick_cnt == TW'(OVS - 1));
        src_pop = (state == SER_IDLE) && !src_empty && !clr;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SER_IDLE: begin
                if (src_pop) state_nx = SER_START;
            end
            SER_START: begin
                if (bit_end) state_nx = SER_DATA;
            end
            SER_DATA: begin
                if (bit_end && bit_idx == IW'(DATA_BITS - 1)) begin
                    state_nx = use_par ? SER_PARITY : SER_STOP;
                end
            end
            SER_PARITY: begin
                if (bit_end) state_nx = SER_STOP;
            end
            SER_STOP: begin
                if (bit_end && !extra_stop) state_nx = SER_IDLE;
            end
            default: state_nx = SER_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= SER_IDLE;
            shreg      <= '0;
            tick_cnt   <= '0;
            bit_idx    <= '0;
            par_bit    <= 1'b0;
            use_par    <= 1'b0;
            extra_stop <= 1'b0;
        end else if (clr) begin
            state    <= SER_IDLE;
            tick_cnt <= '0;
        end else begin
            state <= state_nx;
            if (src_pop) begin
                shreg      <= src_data;
                tick_cnt   <= '0;
                bit_idx    <= '0;
                par_bit    <= par_even ? (^src_data) : ~(^src_data);
                use_par    <= par_en;
                extra_stop <= two_stop;
            end else if (state != SER_IDLE && baud_tick) begin
                tick_cnt <= bit_end ? '0 : tick_cnt + TW'(1);
                if (bit_end) begin
                    if (state == SER_DATA) begin
                        shreg   <= {1'b0, shreg[DATA_BITS-1:1]};
                        bit_idx <= bit_idx + IW'(1);
                    end
                    if (state == SER_STOP) begin
                        extra_stop <= 1'b0;
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state != SER_IDLE);
        unique case (state)
            SER_IDLE:   txd = 1'b1;
            SER_START:  txd = 1'b0;
            SER_DATA:   txd = shreg[0];
            SER_PARITY: txd = par_bit;
            SER_STOP:   txd = 1'b1;
            default:    txd = 1'b1;
        endcase
    end

    p_line_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick && !clr) |=> $stable(txd))
        else $error("line moved between baud ticks");

endmodule

// File: rtl/txq_thre_ctrl.sv
module txq_thre_ctrl
    import uart_txq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CT_W  = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            baud_tick,
    input  logic [CW-1:0]   level,
    input  logic            push,
    input  logic            irq_ack,
    input  logic [CT_W-1:0] char_ticks,
    output logic            pend
);

    holdoff_state_e  state;
    holdoff_state_e  state_nx;
    logic [CT_W-1:0] timer;
    logic            q_empty;
    logic            timer_done;
    logic            set_evt;

    always_comb begin
        q_empty    = (level == '0);
        timer_done = (state == HO_WAIT) && baud_tick &&
                     (timer == char_ticks - CT_W'(1));
        set_evt    = ((state == HO_WAIT) && q_empty && timer_done) ||
                     ((state == HO_OPEN) && q_empty);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            HO_ARMED: begin
                if (!q_empty) state_nx = HO_FIRST;
            end
            HO_FIRST: begin
                if (q_empty)                  state_nx = HO_WAIT;
                else if (level >= CW'(2))     state_nx = HO_OPEN;
            end
            HO_WAIT: begin
                if (!q_empty)                 state_nx = HO_FIRST;
                else if (timer_done)          state_nx = HO_ARMED;
            end
            HO_OPEN: begin
                if (q_empty)                  state_nx = HO_ARMED;
            end
            default: state_nx = HO_ARMED;
        endcase
    end

    // State register, wait timer and pending flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HO_ARMED;
            timer <= '0;
            pend  <= 1'b1;
        end else if (clr) begin
            state <= HO_ARMED;
            timer <= '0;
            pend  <= 1'b1;
        end else begin
            state <= state_nx;
            if (state == HO_WAIT && state_nx == HO_WAIT) begin
                timer <= baud_tick ? timer + CT_W'(1) : timer;
            end else begin
                timer <= '0;
            end
            if (push || irq_ack) begin
                pend <= 1'b0;
            end else if (set_evt) begin
                pend <= 1'b1;
            end
        end
    end

    p_quiet_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HO_WAIT) |-> !pend)
        else $error("pending flag raised during holdoff wait");

    p_open_fires_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HO_OPEN && q_empty && !push && !irq_ack && !clr) |=> pend)
        else $error("disarmed emptying did not flag at once");

endmodule

// File: rtl/uart_txq_holdoff.sv
module uart_txq_holdoff
    import uart_txq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int CT_W = $clog2(OVS * (DATA_BITS + 4) + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_clr,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 irq_en,
    input  logic                 irq_ack,
    input  logic                 baud_tick,
    input  logic                 par_en,
    input  logic                 par_even,
    input  logic                 two_stop,
    output logic                 txd,
    output logic                 wr_ack,
    output logic                 hold_empty,
    output logic                 xmit_empty,
    output logic                 irq
);

    logic                 q_full;
    logic                 q_empty;
    logic                 q_pop;
    logic [DATA_BITS-1:0] q_head;
    logic [CW-1:0]        q_level;
    logic                 ser_busy;
    logic                 pend;
    logic [CT_W-1:0]      char_ticks;

    always_comb begin
        wr_ack     = wr_en && !q_full && !fifo_clr;
        char_ticks = CT_W'(OVS * frame_bits(DATA_BITS, par_en, two_stop));
        hold_empty = q_empty;
        xmit_empty = q_empty && !ser_busy;
        irq        = pend && irq_en;
    end

    txq_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (DATA_BITS)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (wr_ack),
        .push_data (wr_data),
        .pop       (q_pop),
        .pop_data  (q_head),
        .level     (q_level),
        .empty     (q_empty),
        .full      (q_full)
    );

    txq_serializer #(
        .DATA_BITS (DATA_BITS),
        .OVS       (OVS)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .baud_tick (baud_tick),
        .par_en    (par_en),
        .par_even  (par_even),
        .two_stop  (two_stop),
        .src_empty (q_empty),
        .src_data  (q_head),
        .src_pop   (q_pop),
        .txd       (txd),
        .busy      (ser_busy)
    );

    txq_thre_ctrl #(
        .DEPTH (DEPTH),
        .CT_W  (CT_W)
    ) u_holdoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .baud_tick  (baud_tick),
        .level      (q_level),
        .push       (wr_ack),
        .irq_ack    (irq_ack),
        .char_ticks (char_ticks),
        .pend       (pend)
    );

    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !fifo_clr) |=> !irq)
        else $error("irq still high after accepted write");

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !fifo_clr) |=> !irq)
        else $error("irq still high after acknowledge");

endmodule

// File: tb/uart_txq_holdoff_test.sv
`timescale 1ns/1ps
module uart_txq_holdoff_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       baud_tick = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       two_stop = 1'b0;
    logic       txd, wr_ack, hold_empty, xmit_empty, irq;

    int         n_chk = 0;
    int         n_bad = 0;
    int         tdiv = 1;
    bit         mon_en = 1'b1;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    uart_txq_holdoff uut (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .wr_en(wr_en),
        .wr_data(wr_data), .irq_en(irq_en), .irq_ack(irq_ack),
        .baud_tick(baud_tick), .par_en(par_en), .par_even(par_even),
        .two_stop(two_stop), .txd(txd), .wr_ack(wr_ack),
        .hold_empty(hold_empty), .xmit_empty(xmit_empty), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // baud tick generator: one pulse every tdiv cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt + 1 >= tdiv) ? 0 : cnt + 1;
            baud_tick = (cnt == 0);
        end
    end

    // driver: one write attempt per cycle, expected bytes pushed on acceptance
    task automatic put(input logic [7:0] d, output bit acc);
        wr_en = 1'b1;
        wr_data = d;
        #1;
        acc = wr_ack;
        if (acc && mon_en) exp_q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put1(input logic [7:0] d);
        bit a;
        put(d, a);
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_hold_empty();
        int g = 0;
        do begin @(negedge clk); g++; end while (!hold_empty && g < 20000);
    endtask

    task automatic wait_idle();
        int g = 0;
        while (!xmit_empty && g < 20000) begin @(negedge clk); g++; end
        wait_cycles(4);
    endtask

    // holdoff window after an emptying seen at the current negedge
    task automatic check_holdoff(input int bits, input string req);
        int lim = 16 * bits * tdiv;
        wait_cycles(lim - 4);
        check(irq == 1'b0, {req, " irq early"}, irq, 0);
        wait_cycles(10);
        check(irq == 1'b1, {req, " irq after char time"}, irq, 1);
    endtask

    // monitor: decode frames and compare with the scoreboard queue
    task automatic rx_frame();
        logic [7:0] b;
        logic       pexp;
        logic [7:0] e;
        wait_cycles(8 * tdiv);
        check(txd == 1'b0, "R3 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            wait_cycles(16 * tdiv);
            b[i] = txd;
        end
        if (par_en) begin
            wait_cycles(16 * tdiv);
            pexp = par_even ? ^b : ~^b;
            check(txd == pexp, "R3 parity bit", txd, pexp);
        end
        wait_cycles(16 * tdiv);
        check(txd == 1'b1, "R3 stop bit", txd, 1);
        if (two_stop) begin
            wait_cycles(16 * tdiv);
            check(txd == 1'b1, "R12 second stop bit", txd, 1);
        end
        if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected frame", b, 0);
        end else begin
            e = exp_q.pop_front();
            check(b == e, "R3 frame data", b, e);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rst_n && txd == 1'b0) rx_frame();
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int  acks;
        int  waitc;
        bit  a;
        int  lows;

        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);

        // reset state
        check(txd == 1'b1, "R3 idle line", txd, 1);
        check(hold_empty == 1'b1, "R4 hold_empty at reset", hold_empty, 1);
        check(xmit_empty == 1'b1, "R4 xmit_empty at reset", xmit_empty, 1);
        check(irq == 1'b0, "R5 masked irq", irq, 0);
        irq_en = 1'b1;
        #1;
        check(irq == 1'b1, "R5 pending after reset", irq, 1);
        @(negedge clk);

        // single byte: write clears, holdoff delays the next flag
        put1(8'hA5);
        check(irq == 1'b0, "R6 write clears irq", irq, 0);
        wait_hold_empty();
        check(xmit_empty == 1'b0, "R4 shift register still busy", xmit_empty, 0);
        check_holdoff(10, "R8");
        ack_irq();
        check(irq == 1'b0, "R7 acknowledge clears irq", irq, 0);
        wait_idle();

        // late write cancels the wait
        put1(8'h3C);
        wait_hold_empty();
        wait_cycles(80);
        put1(8'hC3);
        check(irq == 1'b0, "R9 write during wait", irq, 0);
        wait_hold_empty();
        check_holdoff(10, "R9");
        ack_irq();
        wait_idle();

        // two resident bytes disarm the holdoff
        put1(8'h11);
        put1(8'h22);
        put1(8'h33);
        wait_hold_empty();
        wait_cycles(2);
        check(irq == 1'b1, "R10 immediate flag after disarm", irq, 1);
        ack_irq();
        wait_idle();
        put1(8'h44);
        wait_hold_empty();
        wait_cycles(20);
        check(irq == 1'b0, "R10 holdoff re-armed", irq, 0);
        wait_idle();
        ack_irq();

        // fill beyond capacity
        acks = 0;
        for (int i = 0; i < 20; i++) begin
            put(8'h50 + 8'(i), a);
            acks += int'(a);
        end
        check(acks == 17, "R1 writes taken into full queue", acks, 17);
        waitc = 0;
        a = 1'b0;
        while (!a && waitc < 400) begin
            put(8'hEE, a);
            waitc++;
        end
        check(a == 1'b1, "R2 write accepted after drain", a, 1);
        check(waitc > 1 && waitc < 320, "R2 reopen time", waitc, 150);
        wait_idle();
        check(exp_q.size() == 0, "R1 all accepted bytes sent", exp_q.size(), 0);
        ack_irq();

        // parity even with two stops, slower tick
        tdiv = 2;
        par_en = 1'b1;
        par_even = 1'b1;
        two_stop = 1'b1;
        wait_cycles(4);
        put1(8'h3D);
        wait_hold_empty();
        check_holdoff(12, "R12");
        wait_idle();
        ack_irq();
        par_even = 1'b0;
        two_stop = 1'b0;
        put1(8'h81);
        put1(8'h07);
        wait_idle();
        wait_cycles(20);
        tdiv = 1;
        par_en = 1'b0;
        wait_cycles(4);

        // mask keeps pending
        ack_irq();
        irq_en = 1'b0;
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        check(irq == 1'b0, "R5 masked pending", irq, 0);
        irq_en = 1'b1;
        #1;
        check(irq == 1'b1, "R5 pending kept while masked", irq, 1);
        @(negedge clk);

        // flush mid-frame
        mon_en = 1'b0;
        put1(8'h01);
        put1(8'h02);
        put1(8'h03);
        put1(8'h04);
        wait_cycles(30);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        check(hold_empty == 1'b1, "R11 hold_empty after flush", hold_empty, 1);
        check(xmit_empty == 1'b1, "R11 xmit_empty after flush", xmit_empty, 1);
        check(irq == 1'b1, "R11 pending after flush", irq, 1);
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check(lows == 0, "R11 line idle after flush", lows, 0);
        mon_en = 1'b1;
        ack_irq();
        put1(8'h9A);
        wait_hold_empty();
        check_holdoff(10, "R11");
        wait_idle();
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end

endmodule